// File: doc/BRIEF.md
# Event Counter Bank with Byte-Wide Coherent Readout

A bank of independent 32-bit event counters runs on a fast count clock, each advancing by one on every cycle in which its own enable bit is high. A slow host with an 8-bit data path reads any counter as four single-byte reads. It presents a counter index and a byte lane, then pulls an active-low read strobe. The strobe is asynchronous to the count clock. It is brought into the count domain through a two-flip-flop synchronizer, and its synchronized falling edge produces a one-cycle read-start pulse.

In the default snapshot variant, a read start on lane 0 copies the addressed counter into a 32-bit holding register. Lanes 1 to 3 then return bytes of that same copy, so the four bytes describe one instant even while the counter keeps running. A build-time parameter selects a cheaper skewed variant instead. There, every read start latches only the addressed byte of the live counter into an 8-bit register, so successive bytes may come from different instants. A synchronous clear zeroes the whole bank.

Top module: `ctr_bank`

## Requirements
- R1: Each of the NUM_CTR counters (default 10) is 32 bits wide and increments by exactly one, modulo 2^32, on every rising clock edge where its bit of `cnt_en` is 1. On edges where that bit is 0 it holds its value. Counters do not affect one another.
- R2: After reset every counter is zero and `rd_data` is zero.
- R3: When `clr` is 1 at a rising edge, all counters become zero at that edge, whatever `cnt_en` holds.
- R4: `rd_n` passes through two synchronizing flip-flops. Suppose the edge at which `rd_n` is first sampled low is edge k, after at least three edges sampled high. Then the read start acts at edge k+2 and captures the value the counter held just before edge k+2.
- R5: In snapshot mode, only a read start with `addr_lane` = 0 reloads the holding register. Read starts with lanes 1, 2 and 3 leave the holding register unchanged.
- R6: In snapshot mode, `rd_data` is bits [8*lane+7 : 8*lane] of the holding register, selected combinationally by the current `addr_lane`. Lane 0 is the least significant byte.
- R7: An `addr_idx` of NUM_CTR or above captures the value zero.
- R8: Capture never stalls counting. No enabled count edge is lost during or after a read.
- R9: In skewed mode (SNAPSHOT = 0), every read start, on any lane, latches byte `addr_lane` of the addressed live counter, and `rd_data` shows that latched byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| clr | input | 1 | Synchronous clear of all counters |
| cnt_en | input | NUM_CTR | Per-counter count enable |
| rd_n | input | 1 | Active-low read strobe from the host, asynchronous |
| addr_idx | input | IDX_W | Counter index |
| addr_lane | input | 2 | Byte lane, 0 = least significant |
| rd_data | output | 8 | Read byte |

## Verification
The bench builds two copies of the block side by side.

- **Snapshot copy, default parameters (ten counters, 4-bit index).** This copy covers indexes above the bank, up to 15, and lets all ten counters run with different enable patterns at once.
- **Skewed copy (SNAPSHOT = 0, three counters).** This copy shares the strobe and address with the first. Each strobe therefore shows the same instant in both variants. The snapshot copy holds a lane-0 copy, while the skewed copy re-samples the live byte.

Because the counters keep running while a strobe crosses into the count domain, a capture taken one edge early or late gives a value that differs by one.

// File: rtl/ctr_bank_pkg.sv
package ctr_bank_pkg;

  localparam int CNT_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int LANES   = CNT_W / BYTE_W;
  localparam int LANE_W  = $clog2(LANES);

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Next value of one counter: clear wins, then enable, else hold.
  function automatic cnt_t cnt_next(input cnt_t cur, input logic en, input logic clr);
    if (clr)      return '0;
    else if (en)  return cur + cnt_t'(1);
    else          return cur;
  endfunction

  // Byte selected by a lane number, lane 0 = least significant.
  function automatic byte_t lane_byte(input cnt_t word, input logic [LANE_W-1:0] lane);
    return word[BYTE_W*int'(lane) +: BYTE_W];
  endfunction

endpackage

// File: rtl/ctr_sync.sv
module ctr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ctr_cell.sv
module ctr_cell
  import ctr_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output cnt_t value
);

  cnt_t val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= cnt_next(val_q, en, clr);
  end

  assign value = val_q;

endmodule

// File: rtl/ctr_capture.sv
module ctr_capture
  import ctr_bank_pkg::*;
#(
  parameter int NUM_CTR  = 10,
  parameter int IDX_W    = 4,
  parameter bit SNAPSHOT = 1'b1,
  localparam int HOLD_W  = SNAPSHOT ? CNT_W : BYTE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [IDX_W-1:0]       idx,
  input  logic [LANE_W-1:0]      lane,
  input  logic [NUM_CTR*CNT_W-1:0] cnt_flat,
  output logic [HOLD_W-1:0]      hold,
  output byte_t                  rd_data
);

  cnt_t live_sel;

  // Addressed live counter; indexes past the bank give zero.
  always_comb begin
    live_sel = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (idx == IDX_W'(i)) live_sel = cnt_flat[i*CNT_W +: CNT_W];
    end
  end

  logic [HOLD_W-1:0] hold_q;

  generate
    if (SNAPSHOT) begin : g_snap
      always_ff @(posedge clk) begin
        if (!rst_n)                          hold_q <= '0;
        else if (start && lane == '0)        hold_q <= live_sel;
      end
      assign rd_data = lane_byte(hold_q, lane);
    end else begin : g_skew
      always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (start)  hold_q <= lane_byte(live_sel, lane);
      end
      assign rd_data = hold_q;
    end
  endgenerate

  assign hold = hold_q;

endmodule

// File: rtl/ctr_bank.sv
module ctr_bank
  import ctr_bank_pkg::*;
#(
  parameter int NUM_CTR  = 10,
  parameter int IDX_W    = 4,
  parameter bit SNAPSHOT = 1'b1,
  localparam int HOLD_W  = SNAPSHOT ? CNT_W : BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NUM_CTR-1:0] cnt_en,
  input  logic               rd_n,
  input  logic [IDX_W-1:0]   addr_idx,
  input  logic [1:0]         addr_lane,
  output logic [7:0]         rd_data
);

  // Strobe crossing: two stages, then a falling-edge detector.
  logic rd_sync;
  logic rd_prev_q;
  logic rd_start;

  ctr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rd_n),
    .q     (rd_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_prev_q <= 1'b1;
    else        rd_prev_q <= rd_sync;
  end

  assign rd_start = rd_prev_q & ~rd_sync;

  // Counter bank.
  logic [NUM_CTR*CNT_W-1:0] cnt_flat;

  generate
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
      ctr_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (cnt_en[g]),
        .value (cnt_flat[g*CNT_W +: CNT_W])
      );
    end
  endgenerate

  // Capture path.
  logic [HOLD_W-1:0] hold_val;

  ctr_capture #(.NUM_CTR(NUM_CTR), .IDX_W(IDX_W), .SNAPSHOT(SNAPSHOT)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rd_start),
    .idx      (addr_idx),
    .lane     (addr_lane),
    .cnt_flat (cnt_flat),
    .hold     (hold_val),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/ctr_bank_chk.sv
module ctr_bank_chk
  import ctr_bank_pkg::*;
#(
  parameter int NUM_CTR  = 10,
  parameter int IDX_W    = 4,
  parameter bit SNAPSHOT = 1'b1,
  localparam int HOLD_W  = SNAPSHOT ? CNT_W : BYTE_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr,
  input logic [NUM_CTR-1:0]       cnt_en,
  input logic                     rd_n,
  input logic [IDX_W-1:0]         addr_idx,
  input logic [1:0]               addr_lane,
  input logic                     rd_start,
  input logic [NUM_CTR*CNT_W-1:0] cnt_flat,
  input logic [HOLD_W-1:0]        hold_val
);

  cnt_t sel_live;
  always_comb begin
    sel_live = '0;
    for (int i = 0; i < NUM_CTR; i++)
      if (int'(addr_idx) == i) sel_live = cnt_flat[i*CNT_W +: CNT_W];
  end

  generate
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_per
      AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_en[g]) |=> cnt_flat[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W]) + 32'd1); // R1
      AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !cnt_en[g]) |=> $stable(cnt_flat[g*CNT_W +: CNT_W])); // R1
    end
  endgenerate

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_flat == '0); // R3

  AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> !$past(rd_n, 2)); // R4

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start); // R4

  generate
    if (SNAPSHOT) begin : g_snap_chk
      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_start && addr_lane == 2'd0) |=> $stable(hold_val)); // R5
      AST_CAPTURE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && addr_lane == 2'd0) |=> hold_val == $past(sel_live)); // R8
      AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && addr_lane == 2'd0 && int'(addr_idx) >= NUM_CTR) |=> hold_val == '0); // R7
    end else begin : g_skew_chk
      AST_SKEW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> hold_val == lane_byte($past(sel_live), $past(addr_lane))); // R9
      AST_SKEW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |=> $stable(hold_val)); // R9
    end
  endgenerate

endmodule

bind ctr_bank ctr_bank_chk #(.NUM_CTR(NUM_CTR), .IDX_W(IDX_W), .SNAPSHOT(SNAPSHOT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .cnt_en    (cnt_en),
  .rd_n      (rd_n),
  .addr_idx  (addr_idx),
  .addr_lane (addr_lane),
  .rd_start  (rd_start),
  .cnt_flat  (cnt_flat),
  .hold_val  (hold_val)
);

// File: tb/ctr_bank_tb_top.sv
module ctr_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCTR = 10;
  localparam int NSKW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [NCTR-1:0] cnt_en = '0;
  logic        rd_n = 1'b1;
  logic [3:0]  addr_idx = '0;
  logic [1:0]  addr_lane = '0;
  logic [7:0]  rd_data;
  logic [7:0]  rd_data_skw;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_bank #(.NUM_CTR(NCTR), .IDX_W(4), .SNAPSHOT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(cnt_en), .rd_n(rd_n),
    .addr_idx(addr_idx), .addr_lane(addr_lane), .rd_data(rd_data));

  ctr_bank #(.NUM_CTR(NSKW), .IDX_W(4), .SNAPSHOT(1'b0)) dut_skew (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(cnt_en[NSKW-1:0]), .rd_n(rd_n),
    .addr_idx(addr_idx), .addr_lane(addr_lane), .rd_data(rd_data_skw));

  // Reference counts, kept from the requirement text.
  logic [31:0] model [NCTR];
  always @(posedge clk) begin
    for (int i = 0; i < NCTR; i++) begin
      if (!rst_n || clr)   model[i] <= 32'd0;
      else if (cnt_en[i])  model[i] <= model[i] + 32'd1;
    end
  end

  logic [31:0] snap_exp = '0;

  function automatic logic [7:0] pick(input logic [31:0] w, input int lane);
    logic [31:0] t;
    t = w >> (lane * 8);
    return t[7:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One host strobe; checks both copies after the capture edge.
  task automatic strobe(input int idx, input int lane, input string req);
    logic [31:0] live_main, live_skw;
    @(negedge clk);
    addr_idx = 4'(idx);
    addr_lane = 2'(lane);
    rd_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    live_main = (idx < NCTR) ? model[idx] : 32'd0;
    live_skw  = (idx < NSKW) ? model[idx] : 32'd0;
    @(posedge clk);
    @(negedge clk);
    if (lane == 0) snap_exp = live_main;
    chk(req, {24'd0, rd_data}, {24'd0, pick(snap_exp, lane)});
    chk({req, " R9"}, {24'd0, rd_data_skw}, {24'd0, pick(live_skw, lane)});
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_word(input int idx, input string req);
    for (int l = 0; l < 4; l++) strobe(idx, l, req);
  endtask

  task automatic t_reset();
    chk("R2 rd_data", {24'd0, rd_data}, 32'd0);
    read_word(4, "R2 counter zero");
  endtask

  task automatic t_count();
    @(negedge clk);
    cnt_en = 10'b10_0100_1001;
    repeat (300) @(negedge clk);
    cnt_en = 10'b00_0000_0001;
    repeat (37) @(negedge clk);
    cnt_en = '0;
    read_word(0, "R1 counter0");
    read_word(3, "R1 counter3");
    read_word(9, "R1 counter9");
    read_word(1, "R1 idle counter1");
  endtask

  task automatic t_running();
    @(negedge clk);
    cnt_en = '1;
    repeat (1000) @(negedge clk);
    read_word(5, "R4 R8 running capture");
    read_word(2, "R8 running capture");
    // Lanes without lane 0 keep the old copy while counters move on.
    strobe(2, 0, "R5 fresh copy");
    repeat (50) @(negedge clk);
    strobe(7, 3, "R5 lane3 no recapture");
    strobe(7, 1, "R5 lane1 no recapture");
    // Combinational lane select without a strobe.
    for (int l = 0; l < 4; l++) begin
      @(negedge clk);
      addr_lane = 2'(l);
      #1;
      chk("R6 lane select", {24'd0, rd_data}, {24'd0, pick(snap_exp, l)});
    end
    @(negedge clk);
    cnt_en = '0;
    read_word(5, "R8 no lost counts");
  endtask

  task automatic t_badidx();
    read_word(10, "R7 index 10");
    read_word(15, "R7 index 15");
  endtask

  task automatic t_clear();
    @(negedge clk);
    cnt_en = '1;
    repeat (20) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    cnt_en = '0;
    read_word(0, "R3 clear counter0");
    read_word(9, "R3 clear counter9");
    @(negedge clk);
    cnt_en = 10'b00_0000_0010;
    repeat (9) @(negedge clk);
    cnt_en = '0;
    read_word(1, "R3 count after clear");
  endtask

  task automatic t_skew();
    @(negedge clk);
    cnt_en = 10'b00_0000_0110;
    repeat (700) @(negedge clk);
    read_word(1, "R9 skew running");
    read_word(2, "R9 skew running");
    read_word(6, "R9 skew index past bank");
    @(negedge clk);
    cnt_en = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_count();
    t_running();
    t_badidx();
    t_clear();
    t_skew();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule